// File: doc/BRIEF.md
# Per-thread interrupt presenter register window

This block gives one processor thread a 4 KB memory-mapped window onto its interrupt presenter. Software reaches it with single-byte or 32-bit reads and writes. The block turns each access's offset, width and direction into one register operation:

- peek at the pending interrupt without changing anything;
- take (accept) the pending interrupt;
- change the current processor priority;
- retire an interrupt with an end-of-interrupt write;
- program the inter-processor interrupt (IPI) priority;
- read or write three plain link words.

One offset can mean different operations. The result depends on whether the access is a byte or a word, and on whether it is a read or a write. Any access the window does not define is refused with an error pulse.

Pending interrupts come from a small built-in model. An external requester supplies a level request made of a valid bit, a source number and a priority. A software-raised IPI comes from the IPI priority register. A presentation state machine tracks what is being offered to the thread. Its states are `ST_IDLE` (nothing offered), `ST_EXT` (external source offered) and `ST_IPI` (IPI offered). It has four transitions:

- T_PRESENT_EXT: `ST_IDLE` to `ST_EXT`, when the external request wins.
- T_PRESENT_IPI: `ST_IDLE` to `ST_IPI`, when the IPI wins.
- T_ACCEPT: either presented state to `ST_IDLE`, on an accepting read.
- T_WITHDRAW: either presented state to `ST_IDLE`, on any priority write or end-of-interrupt.

A lower priority number is more favoured. The interrupt word is {current priority[7:0], source field[23:0]}. The source field is zero when nothing is presented.

Top module: `intp_regif`

## Requirements
- R1: Address bits [11:2] alone select the register. Word index 0 selects poll, 1 selects the interrupt word, 3 selects the IPI priority, and 4, 5 and 6 select link words 0, 1 and 2. Every other index is a bad access.
- R2: An access is a byte when size is 1 and a word when size is 4, and either kind needs address bits [1:0] equal to zero. Any other size or alignment is a bad access.
- R3: A byte read at offset 0 or 4 returns the current priority in rdata[7:0], with zeros above, and changes no state.
- R4: A word read at offset 0 returns {current priority, source field} and changes no state.
- R5: A word read at offset 4 returns the same word. If an interrupt is presented, the read also loads the current priority with that interrupt's priority, and the source field and irq read zero from the next cycle on.
- R6: A byte write at offset 4 loads the current priority from wdata[7:0] and withdraws any presented interrupt (irq low the next cycle).
- R7: A word write at offset 4 is end-of-interrupt. It loads the current priority from wdata[31:24] and withdraws any presented interrupt.
- R8: At offset 12 only byte accesses are valid. A byte read returns the IPI priority in rdata[7:0], and a byte write loads it from wdata[7:0] and withdraws any presented interrupt. Word accesses there are bad.
- R9: The link words accept word reads and word writes only, and a write stores all 32 bits.
- R10: A bad access pulses bad_access with its response. A bad read returns 0xFFFFFFFF, and a bad write changes no register.
- R11: In `ST_IDLE` the block picks one candidate each cycle and presents it from the next cycle on, and irq is high exactly while a source is presented. The IPI wins, as source 2, when its priority is below both the current priority and any valid external priority. Otherwise a valid external request with a nonzero source wins when its priority is below the current priority. A presented interrupt is never pre-empted.
- R12: After reset the current priority is 0x00, the IPI priority is 0xFF, the link words are zero, and irq, rsp_valid and bad_access are low.
- R13: rsp_valid, rsp_rdata and bad_access are registered. They describe the access of the previous cycle, and rsp_valid is low after a cycle without a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte offset inside the window |
| req_size | input | 3 | Access width in bytes |
| req_wdata | input | 32 | Write data; bytes in [7:0], words big-endian |
| rsp_valid | output | 1 | Response for the previous cycle's access |
| rsp_rdata | output | 32 | Read data; 0 for good writes |
| bad_access | output | 1 | Pulse: previous access was refused |
| ext_valid | input | 1 | External request level |
| ext_src | input | 24 | External source number |
| ext_prio | input | 8 | External request priority |
| irq | output | 1 | Interrupt line to the thread |

## Verification
The in-RTL assertions check, on every cycle:

- a presented interrupt's priority is always below the current priority;
- an accept or a priority write drops irq on the next cycle;
- link words hold their value unless written;
- an undecoded index or a wrong width raises the error pulse with all-ones data;
- a byte peek never moves the current priority.

Other behaviours need the bench's ordered scenarios. These are the tie between external and IPI priorities, the absence of pre-emption, the re-presentation after end-of-interrupt, and the decoded results across the whole window for each size and alignment.

// File: rtl/intp_pkg.sv
package intp_pkg;

    typedef enum logic [3:0] {
        OP_NONE,
        OP_RD_PRIO,
        OP_POLL,
        OP_ACCEPT,
        OP_SET_CPPR,
        OP_EOI,
        OP_RD_MFRR,
        OP_WR_MFRR,
        OP_RD_LINK,
        OP_WR_LINK,
        OP_BAD
    } op_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_EXT,
        ST_IPI
    } pres_e;

    localparam int unsigned SIZE_BYTE = 1;
    localparam int unsigned SIZE_WORD = 4;

endpackage

// File: rtl/intp_decode.sv
module intp_decode
    import intp_pkg::*;
#(
    parameter int unsigned ADDR_W    = 12,
    parameter int unsigned NUM_LINKS = 3,
    parameter int unsigned LIDX_W    = 2
) (
    input  logic              valid,
    input  logic              write,
    input  logic [ADDR_W-1:0] addr,
    input  logic [2:0]        size,
    output op_e               op,
    output logic [LIDX_W-1:0] link_idx
);
    localparam int unsigned WIDX_W = ADDR_W - 2;
    localparam logic [WIDX_W-1:0] WI_POLL  = WIDX_W'(0);
    localparam logic [WIDX_W-1:0] WI_XIRR  = WIDX_W'(1);
    localparam logic [WIDX_W-1:0] WI_MFRR  = WIDX_W'(3);
    localparam logic [WIDX_W-1:0] WI_LINK0 = WIDX_W'(4);
    localparam logic [WIDX_W-1:0] WI_LEND  = WIDX_W'(4 + NUM_LINKS);

    logic [WIDX_W-1:0] widx;
    logic [WIDX_W-1:0] lsub;
    logic              aligned, is_byte, is_word, link_hit;

    assign widx     = addr[ADDR_W-1:2];
    assign lsub     = widx - WI_LINK0;
    assign link_idx = lsub[LIDX_W-1:0];
    assign aligned  = (addr[1:0] == 2'b00);
    assign is_byte  = aligned && (size == 3'(SIZE_BYTE));
    assign is_word  = aligned && (size == 3'(SIZE_WORD));
    assign link_hit = (widx >= WI_LINK0) && (widx < WI_LEND);

    always_comb begin
        op = OP_BAD;
        if (!valid) begin
            op = OP_NONE;
        end else if (widx == WI_POLL) begin
            if (!write && is_byte)      op = OP_RD_PRIO;
            else if (!write && is_word) op = OP_POLL;
        end else if (widx == WI_XIRR) begin
            if (is_byte)                op = write ? OP_SET_CPPR : OP_RD_PRIO;
            else if (is_word)           op = write ? OP_EOI : OP_ACCEPT;
        end else if (widx == WI_MFRR) begin
            if (is_byte)                op = write ? OP_WR_MFRR : OP_RD_MFRR;
        end else if (link_hit) begin
            if (is_word)                op = write ? OP_WR_LINK : OP_RD_LINK;
        end
    end

endmodule

// File: rtl/intp_present.sv
module intp_present
    import intp_pkg::*;
#(
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned PRIO_W  = 8,
    parameter int unsigned SRC_W   = 24,
    parameter int unsigned IPI_SRC = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  op_e               op,
    input  logic [DATA_W-1:0] wdata,
    input  logic              ext_valid,
    input  logic [SRC_W-1:0]  ext_src,
    input  logic [PRIO_W-1:0] ext_prio,
    output logic [PRIO_W-1:0] cppr,
    output logic [PRIO_W-1:0] mfrr,
    output logic [SRC_W-1:0]  xisr,
    output logic              irq
);
    pres_e             state, nstate;
    logic [PRIO_W-1:0] ncppr, nmfrr, pend_prio, npprio;
    logic [SRC_W-1:0]  pend_src, npsrc;
    logic              ipi_win, ext_win;

    assign ipi_win = (mfrr < cppr) && (!ext_valid || (mfrr < ext_prio));
    assign ext_win = ext_valid && (ext_src != '0) && (ext_prio < cppr);

    always_comb begin
        nstate = state;
        ncppr  = cppr;
        nmfrr  = mfrr;
        npsrc  = pend_src;
        npprio = pend_prio;
        unique case (state)
            ST_IDLE: begin
                if (ipi_win) begin                // T_PRESENT_IPI
                    nstate = ST_IPI;
                    npsrc  = SRC_W'(IPI_SRC);
                    npprio = mfrr;
                end else if (ext_win) begin       // T_PRESENT_EXT
                    nstate = ST_EXT;
                    npsrc  = ext_src;
                    npprio = ext_prio;
                end
            end
            ST_EXT, ST_IPI: ;
            default: nstate = ST_IDLE;
        endcase
        case (op)
            OP_ACCEPT: if (state != ST_IDLE) begin // T_ACCEPT
                ncppr  = pend_prio;
                nstate = ST_IDLE;
            end
            OP_SET_CPPR: begin                    // T_WITHDRAW
                ncppr  = wdata[PRIO_W-1:0];
                nstate = ST_IDLE;
            end
            OP_EOI: begin                         // T_WITHDRAW
                ncppr  = wdata[DATA_W-1 -: PRIO_W];
                nstate = ST_IDLE;
            end
            OP_WR_MFRR: begin                     // T_WITHDRAW
                nmfrr  = wdata[PRIO_W-1:0];
                nstate = ST_IDLE;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            cppr      <= '0;
            mfrr      <= '1;
            pend_src  <= '0;
            pend_prio <= '1;
        end else begin
            state     <= nstate;
            cppr      <= ncppr;
            mfrr      <= nmfrr;
            pend_src  <= npsrc;
            pend_prio <= npprio;
        end
    end

    always_comb begin
        irq  = (state != ST_IDLE);
        xisr = (state == ST_IDLE) ? '0 : pend_src;
    end

    // R11: anything presented must beat the current priority
    a_r11_presented_beats_cppr: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (pend_prio < cppr));

    // R5: accepting a presented interrupt drops irq and adopts its priority
    a_r5_accept_takes_prio: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_ACCEPT && irq) |=> (!irq && cppr == $past(pend_prio)));

    // R6: a priority write withdraws the presented interrupt
    a_r6_cppr_write_withdraws: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_SET_CPPR) |=> !irq);

    // R7: end-of-interrupt withdraws and loads the top byte
    a_r7_eoi_loads_top: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_EOI) |=> (!irq && cppr == $past(wdata[DATA_W-1 -: PRIO_W])));

endmodule

// File: rtl/intp_links.sv
module intp_links #(
    parameter int unsigned NUM_LINKS = 3,
    parameter int unsigned DATA_W    = 32,
    parameter int unsigned LIDX_W    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [LIDX_W-1:0] idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] link_q [NUM_LINKS];

    for (genvar i = 0; i < NUM_LINKS; i++) begin : g_link
        always_ff @(posedge clk) begin
            if (!rst_n)
                link_q[i] <= '0;
            else if (wr_en && idx == LIDX_W'(i))
                link_q[i] <= wdata;
        end

        // R9: a link word only changes when it is the write target
        a_r9_link_holds: assert property (@(posedge clk) disable iff (!rst_n)
            !(wr_en && idx == LIDX_W'(i)) |=> $stable(link_q[i]));
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_LINKS; i++)
            if (idx == LIDX_W'(i)) rdata = link_q[i];
    end

endmodule

// File: rtl/intp_regif.sv
module intp_regif
    import intp_pkg::*;
#(
    parameter int unsigned ADDR_W    = 12,
    parameter int unsigned DATA_W    = 32,
    parameter int unsigned PRIO_W    = 8,
    parameter int unsigned SRC_W     = 24,
    parameter int unsigned NUM_LINKS = 3,
    parameter int unsigned IPI_SRC   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [2:0]        req_size,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              bad_access,
    input  logic              ext_valid,
    input  logic [SRC_W-1:0]  ext_src,
    input  logic [PRIO_W-1:0] ext_prio,
    output logic              irq
);
    localparam int unsigned LIDX_W = (NUM_LINKS > 1) ? $clog2(NUM_LINKS) : 1;
    localparam int unsigned WIDX_W = ADDR_W - 2;

    op_e               op;
    logic [LIDX_W-1:0] link_idx;
    logic [PRIO_W-1:0] cppr, mfrr;
    logic [SRC_W-1:0]  xisr;
    logic [DATA_W-1:0] link_rdata, rd_mux;
    logic [WIDX_W-1:0] widx;

    assign widx = req_addr[ADDR_W-1:2];

    intp_decode #(.ADDR_W(ADDR_W), .NUM_LINKS(NUM_LINKS), .LIDX_W(LIDX_W)) u_decode (
        .valid(req_valid), .write(req_write), .addr(req_addr), .size(req_size),
        .op(op), .link_idx(link_idx)
    );

    intp_present #(.DATA_W(DATA_W), .PRIO_W(PRIO_W), .SRC_W(SRC_W), .IPI_SRC(IPI_SRC)) u_present (
        .clk(clk), .rst_n(rst_n), .op(op), .wdata(req_wdata),
        .ext_valid(ext_valid), .ext_src(ext_src), .ext_prio(ext_prio),
        .cppr(cppr), .mfrr(mfrr), .xisr(xisr), .irq(irq)
    );

    intp_links #(.NUM_LINKS(NUM_LINKS), .DATA_W(DATA_W), .LIDX_W(LIDX_W)) u_links (
        .clk(clk), .rst_n(rst_n), .wr_en(op == OP_WR_LINK), .idx(link_idx),
        .wdata(req_wdata), .rdata(link_rdata)
    );

    always_comb begin
        unique case (op)
            OP_RD_PRIO:         rd_mux = DATA_W'(cppr);
            OP_POLL, OP_ACCEPT: rd_mux = {cppr, xisr};
            OP_RD_MFRR:         rd_mux = DATA_W'(mfrr);
            OP_RD_LINK:         rd_mux = link_rdata;
            OP_BAD:             rd_mux = req_write ? '0 : '1;
            default:            rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid  <= 1'b0;
            rsp_rdata  <= '0;
            bad_access <= 1'b0;
        end else begin
            rsp_valid  <= req_valid;
            rsp_rdata  <= rd_mux;
            bad_access <= (op == OP_BAD);
        end
    end

    // R13: a response follows every request and only requests
    a_r13_rsp_tracks_req: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    a_r13_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!rsp_valid && !bad_access));

    // R1: indices beyond the last link word are refused with all-ones data
    a_r1_undecoded_bad: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && widx >= WIDX_W'(4 + NUM_LINKS))
        |=> (bad_access && rsp_rdata == '1));

    // R2: a size that is neither byte nor word is refused
    a_r2_odd_size_bad: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_size != 3'(SIZE_BYTE) && req_size != 3'(SIZE_WORD)) |=> bad_access);

    // R3: a byte peek leaves the current priority alone
    a_r3_peek_keeps_cppr: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && req_size == 3'(SIZE_BYTE) && req_addr == '0)
        |=> (cppr == $past(cppr)));

endmodule

// File: tb/intp_regif_tb.sv
`timescale 1ns/1ps
module intp_regif_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [11:0] req_addr = '0;
    logic [2:0]  req_size = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid, bad_access, irq;
    logic [31:0] rsp_rdata;
    logic        ext_valid = 1'b0;
    logic [23:0] ext_src = '0;
    logic [7:0]  ext_prio = '1;

    int tests = 0, fails = 0;
    logic [31:0] got_d;
    logic        got_b, got_v;
    logic [7:0]  m_cppr, m_mfrr;
    logic [31:0] m_link [3];

    always #2 clk = ~clk;

    intp_regif u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .bad_access(bad_access),
        .ext_valid(ext_valid), .ext_src(ext_src), .ext_prio(ext_prio), .irq(irq)
    );

    task automatic check(input string rq, input logic [32:0] act, input logic [32:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", rq, act, exp);
        end
    endtask

    task automatic acc(input logic w, input logic [11:0] a, input logic [2:0] s, input logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = w; req_addr = a; req_size = s; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
        got_d = rsp_rdata; got_b = bad_access; got_v = rsp_valid;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // expected {bad, data} of a read while nothing is presented
    function automatic logic [32:0] model_rd(input logic [11:0] a, input logic [2:0] s);
        logic [9:0] wi = a[11:2];
        logic byte_ok = (s == 3'd1) && (a[1:0] == 2'b00);
        logic word_ok = (s == 3'd4) && (a[1:0] == 2'b00);
        if ((wi == 10'd0 || wi == 10'd1) && byte_ok) return {1'b0, 24'h0, m_cppr};
        if ((wi == 10'd0 || wi == 10'd1) && word_ok) return {1'b0, m_cppr, 24'h0};
        if (wi == 10'd3 && byte_ok) return {1'b0, 24'h0, m_mfrr};
        if (wi >= 10'd4 && wi <= 10'd6 && word_ok) return {1'b0, m_link[wi - 10'd4]};
        return {1'b1, 32'hFFFF_FFFF};
    endfunction

    task automatic sweep();
        for (int wi = 0; wi < 1024; wi++) begin
            acc(1'b0, 12'(wi * 4), 3'd4, 32'h0);
            check("R1 word sweep", {got_b, got_d}, model_rd(12'(wi * 4), 3'd4));
        end
        for (int wi = 0; wi < 8; wi++)
            for (int lo = 0; lo < 4; lo++)
                for (int s = 1; s <= 4; s++) begin
                    acc(1'b0, 12'(wi * 4 + lo), 3'(s), 32'h0);
                    check("R2 size/align sweep", {got_b, got_d}, model_rd(12'(wi * 4 + lo), 3'(s)));
                end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL R13 watchdog: actual 200000 cycles expected earlier finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        m_cppr = 8'h00; m_mfrr = 8'hFF;
        for (int i = 0; i < 3; i++) m_link[i] = '0;
        idle(3);
        rst_n = 1'b1;
        idle(1);
        // R12 reset state
        check("R12 irq", {32'h0, irq}, 33'h0);
        check("R12 rsp", {31'h0, rsp_valid, bad_access}, 33'h0);
        sweep();

        // R9 link words
        acc(1'b1, 12'h010, 3'd4, 32'hAABB_CCDD); m_link[0] = 32'hAABB_CCDD;
        check("R9 link write ok", {32'h0, got_b}, 33'h0);
        acc(1'b1, 12'h014, 3'd4, 32'h1122_3344); m_link[1] = 32'h1122_3344;
        acc(1'b1, 12'h018, 3'd4, 32'h5566_7788); m_link[2] = 32'h5566_7788;
        acc(1'b0, 12'h014, 3'd4, 32'h0);
        check("R9 link readback", {got_b, got_d}, {1'b0, 32'h1122_3344});
        // R8 IPI priority byte write (current priority 0 blocks presentation)
        acc(1'b1, 12'h00C, 3'd1, 32'h0000_007E); m_mfrr = 8'h7E;
        check("R8 mfrr byte write", {32'h0, got_b}, 33'h0);

        // R10 bad writes leave every register unchanged
        acc(1'b1, 12'h000, 3'd4, 32'hDEAD_BEEF); check("R10 write poll", {32'h0, got_b}, 33'h1);
        acc(1'b1, 12'h000, 3'd1, 32'h0000_0055); check("R10 byte write poll", {32'h0, got_b}, 33'h1);
        acc(1'b1, 12'h00C, 3'd4, 32'h0000_0011); check("R8 word write mfrr", {32'h0, got_b}, 33'h1);
        acc(1'b1, 12'h010, 3'd1, 32'h0000_0022); check("R9 byte write link", {32'h0, got_b}, 33'h1);
        acc(1'b1, 12'h004, 3'd2, 32'h0000_0033); check("R2 half write", {32'h0, got_b}, 33'h1);
        acc(1'b1, 12'h005, 3'd1, 32'h0000_0044); check("R2 unaligned byte", {32'h0, got_b}, 33'h1);
        acc(1'b1, 12'h01C, 3'd4, 32'h0000_0066); check("R1 undecoded write", {32'h0, got_b}, 33'h1);
        acc(1'b1, 12'hFFC, 3'd4, 32'h0000_0077); check("R1 top write", {32'h0, got_b}, 33'h1);
        idle(1);
        check("R13 no rsp when idle", {31'h0, rsp_valid, bad_access}, 33'h0);
        sweep();

        // presentation scenarios
        acc(1'b1, 12'h00C, 3'd1, 32'h0000_00FF); m_mfrr = 8'hFF;
        acc(1'b1, 12'h004, 3'd1, 32'h0000_00FF); m_cppr = 8'hFF;
        idle(2);
        check("R6 cppr byte write", {got_b, 32'h0}, 33'h0);
        acc(1'b0, 12'h000, 3'd1, 32'h0);
        check("R3 byte peek", {got_b, got_d}, {1'b0, 32'h0000_00FF});
        check("R11 nothing pending", {32'h0, irq}, 33'h0);

        ext_src = 24'h000123; ext_prio = 8'h05; ext_valid = 1'b1;
        idle(1);
        check("R11 ext presented", {32'h0, irq}, 33'h1);
        acc(1'b0, 12'h000, 3'd4, 32'h0);
        check("R4 poll word", {got_b, got_d}, {1'b0, 32'hFF00_0123});
        check("R4 poll keeps irq", {32'h0, irq}, 33'h1);
        acc(1'b0, 12'h004, 3'd1, 32'h0);
        check("R3 byte read at 4", {got_b, got_d}, {1'b0, 32'h0000_00FF});
        acc(1'b0, 12'h004, 3'd4, 32'h0);
        check("R5 accept data", {got_b, got_d}, {1'b0, 32'hFF00_0123});
        check("R5 accept drops irq", {32'h0, irq}, 33'h0);
        acc(1'b0, 12'h000, 3'd4, 32'h0);
        check("R5 prio after accept", {got_b, got_d}, {1'b0, 32'h0500_0000});
        ext_valid = 1'b0;

        acc(1'b1, 12'h004, 3'd4, 32'hFF00_0123);
        idle(2);
        acc(1'b0, 12'h000, 3'd4, 32'h0);
        check("R7 eoi restores prio", {got_b, got_d}, {1'b0, 32'hFF00_0000});

        acc(1'b1, 12'h00C, 3'd1, 32'h0000_0010);
        idle(2);
        acc(1'b0, 12'h000, 3'd4, 32'h0);
        check("R11 ipi presented", {got_b, got_d}, {1'b0, 32'hFF00_0002});
        acc(1'b0, 12'h00C, 3'd1, 32'h0);
        check("R8 mfrr byte read", {got_b, got_d}, {1'b0, 32'h0000_0010});

        ext_src = 24'h000045; ext_prio = 8'h08; ext_valid = 1'b1;
        idle(2);
        acc(1'b0, 12'h000, 3'd4, 32'h0);
        check("R11 no preemption", {got_b, got_d}, {1'b0, 32'hFF00_0002});
        acc(1'b1, 12'h00C, 3'd1, 32'h0000_0008);
        idle(2);
        acc(1'b0, 12'h000, 3'd4, 32'h0);
        check("R11 tie goes external", {got_b, got_d}, {1'b0, 32'hFF00_0045});

        acc(1'b1, 12'h004, 3'd1, 32'h0000_0004);
        idle(2);
        check("R6 withdraw irq", {32'h0, irq}, 33'h0);
        acc(1'b0, 12'h000, 3'd4, 32'h0);
        check("R6 new prio blocks", {got_b, got_d}, {1'b0, 32'h0400_0000});

        acc(1'b1, 12'h004, 3'd4, 32'hFF00_0000);
        ext_prio = 8'h20;
        acc(1'b1, 12'h00C, 3'd1, 32'h0000_0008);
        idle(2);
        acc(1'b0, 12'h004, 3'd4, 32'h0);
        check("R5 accept ipi", {got_b, got_d}, {1'b0, 32'hFF00_0002});
        idle(2);
        check("R5 ipi accepted, ext blocked", {32'h0, irq}, 33'h0);
        acc(1'b0, 12'h000, 3'd4, 32'h0);
        check("R5 prio is ipi prio", {got_b, got_d}, {1'b0, 32'h0800_0000});
        check("R13 rsp valid", {32'h0, got_v}, 33'h1);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule